// File: doc/BRIEF.md
# Settable 24-Hour Time Counter

This block counts wall-clock time as three binary fields: hours (0 to 23), minutes (0 to 59) and seconds (0 to 59). A free-running square wave of roughly one second period drives it. Each low-to-high transition of that wave advances the time by one second, and the carry ripples into minutes and hours. The block neither makes the one-second wave nor drives a display. A separate divider produces the wave, and a display scanner reads the three fields.

A mode switch selects run or adjust. In adjust mode the block ignores the one-second wave. Three push-buttons then step seconds, minutes or hours one at a time. Each button passes through a slow filter that samples the button at a fixed interval and reports it pressed only after three samples in a row are high. A step changes only the field it belongs to. That field wraps to zero at its limit and does not carry into the next field. An indicator output follows the mode switch. The block has no streaming data path, so every pin is a plain level signal with no handshake.

Top module: `hms_keeper`

## Requirements
- R1: After reset `sec_o`, `min_o` and `hr_o` are all zero. `sec_o` and `min_o` never exceed 59 and `hr_o` never exceeds 23.
- R2: While `adj_sw` is low, every rising edge of `tick_in` adds one second. 59 seconds becomes 0 and adds one minute. 59 minutes becomes 0 and adds one hour. 23 hours becomes 0.
- R3: A high level on `tick_in` advances the time only once, however long it lasts.
- R4: While `adj_sw` is high, `tick_in` has no effect and the time fields hold unless a button step occurs.
- R5: Each button is sampled once every `DEB_WAIT` clock cycles. It reads as pressed only while its last three samples are all high, so a pulse covering fewer than three samples changes nothing.
- R6: In adjust mode, each debounced press of `btn_sec`, `btn_min` or `btn_hr` adds one to that field only. Seconds and minutes wrap 59 to 0 and hours wrap 23 to 0, with no carry into another field.
- R7: Leaving adjust mode while `tick_in` is high does not count that high level as an edge. Button edge state is cleared outside adjust mode, so a button still held when adjust mode is entered again counts as a new press.
- R8: `adj_led` equals `adj_sw` at all times.
- R9: `tick_in`, `adj_sw` and the buttons pass through two-flop synchronizers. A tick that rises before clock edge k changes the fields at edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | One-second square wave |
| adj_sw | input | 1 | High selects adjust mode |
| btn_sec | input | 1 | Raw button, steps seconds |
| btn_min | input | 1 | Raw button, steps minutes |
| btn_hr | input | 1 | Raw button, steps hours |
| adj_led | output | 1 | Copy of `adj_sw` |
| sec_o | output | 6 | Seconds, binary 0..59 |
| min_o | output | 6 | Minutes, binary 0..59 |
| hr_o | output | 5 | Hours, binary 0..23 |

## Verification
A tick rising before edge k reaches the fields on the third edge: two synchronizer stages, then the field register. The bench checks both the edge before the update (old value) and the update edge (new value). A button press takes effect at the first sample slot where three samples are high, and then one edge later in the field register. The bench's behavioural model advances on the same edges and is compared at every falling edge, so no result is read at the moment it changes. Directed checks are taken only after quiet intervals, well after every pending update has settled.

// File: rtl/hms_pkg.sv
package hms_pkg;
  localparam int unsigned SEC_W   = 6;
  localparam int unsigned HR_W    = 5;
  localparam int unsigned SEC_MAX = 59;
  localparam int unsigned HR_MAX  = 23;
  localparam int unsigned N_BTN   = 3;
  // synchronizer lane assignment
  localparam int unsigned LANE_TICK = 0;
  localparam int unsigned LANE_ADJ  = 1;
  localparam int unsigned LANE_BTN0 = 2;
  localparam int unsigned N_LANE    = LANE_BTN0 + N_BTN;
  typedef enum logic [1:0] {F_SEC = 2'd0, F_MIN = 2'd1, F_HR = 2'd2} field_e;
endpackage

// File: rtl/hms_sync.sv
module hms_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hms_debounce.sv
module hms_debounce #(
  parameter int unsigned WAIT = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int unsigned CW = (WAIT > 1) ? $clog2(WAIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAIT - 1);

  logic [CW-1:0] cnt;
  logic [2:0]    hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      hist <= '0;
    end else begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (cnt == '0) hist <= {hist[1:0], raw};
    end
  end

  assign clean = &hist;

  AST_DEB_SAMPLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clean) |-> $past(cnt) == '0); // R5
endmodule

// File: rtl/hms_field.sv
module hms_field #(
  parameter int unsigned W   = 6,
  parameter int unsigned MAX = 59
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] val,
  output logic         at_max
);
  localparam logic [W-1:0] TOP = W'(MAX);

  assign at_max = (val == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    val <= '0;
    else if (step) val <= at_max ? '0 : val + 1'b1;
  end

  AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_max) |=> val == '0); // R2
  AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    val <= TOP); // R1
endmodule

// File: rtl/hms_keeper.sv
module hms_keeper
  import hms_pkg::*;
#(
  parameter int unsigned DEB_WAIT = 2500000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_in,
  input  logic            adj_sw,
  input  logic            btn_sec,
  input  logic            btn_min,
  input  logic            btn_hr,
  output logic            adj_led,
  output logic [SEC_W-1:0] sec_o,
  output logic [SEC_W-1:0] min_o,
  output logic [HR_W-1:0]  hr_o
);
  logic [N_LANE-1:0] raw_in, sync_q;
  logic              tick_s, adj_s, tick_armed_n;
  logic [N_BTN-1:0]  btn_s, btn_clean, btn_seen, btn_step;
  logic              tick_step, sec_max, min_max, hr_max;
  logic              sec_step, min_step, hr_step;

  assign raw_in  = {btn_hr, btn_min, btn_sec, adj_sw, tick_in};
  assign adj_led = adj_sw;

  hms_sync #(.W(N_LANE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_q)
  );

  assign tick_s = sync_q[LANE_TICK];
  assign adj_s  = sync_q[LANE_ADJ];
  assign btn_s  = sync_q[LANE_BTN0 +: N_BTN];

  for (genvar i = 0; i < N_BTN; i++) begin : g_btn
    hms_debounce #(.WAIT(DEB_WAIT)) u_deb (
      .clk(clk), .rst_n(rst_n), .raw(btn_s[i]), .clean(btn_clean[i])
    );
    assign btn_step[i] = adj_s && btn_clean[i] && !btn_seen[i];
  end

  // tick armed/fired flag; in adjust mode it tracks the level so exit sees no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_armed_n <= 1'b0;
      btn_seen     <= '0;
    end else begin
      if (adj_s)       tick_armed_n <= tick_s;
      else if (tick_s) tick_armed_n <= 1'b1;
      else             tick_armed_n <= 1'b0;
      btn_seen <= adj_s ? btn_clean : '0;
    end
  end

  assign tick_step = !adj_s && tick_s && !tick_armed_n;
  assign sec_step  = adj_s ? btn_step[F_SEC] : tick_step;
  assign min_step  = adj_s ? btn_step[F_MIN] : (tick_step && sec_max);
  assign hr_step   = adj_s ? btn_step[F_HR]  : (tick_step && sec_max && min_max);

  hms_field #(.W(SEC_W), .MAX(SEC_MAX)) u_sec (
    .clk(clk), .rst_n(rst_n), .step(sec_step), .val(sec_o), .at_max(sec_max)
  );
  hms_field #(.W(SEC_W), .MAX(SEC_MAX)) u_min (
    .clk(clk), .rst_n(rst_n), .step(min_step), .val(min_o), .at_max(min_max)
  );
  hms_field #(.W(HR_W), .MAX(HR_MAX)) u_hr (
    .clk(clk), .rst_n(rst_n), .step(hr_step), .val(hr_o), .at_max(hr_max)
  );

  AST_ADJ_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_s && btn_step == '0) |=> $stable({hr_o, min_o, sec_o})); // R4
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_step |=> !tick_step); // R3
  AST_ADJ_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_s && sec_step && sec_max && !min_step) |=> $stable(min_o)); // R6
  AST_EXIT_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(adj_s) && tick_s && $past(tick_s)) |-> !tick_step); // R7
  AST_HR_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_step && hr_max) |=> hr_o == '0); // R2
endmodule

// File: tb/hms_keeper_tb.sv
module hms_keeper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_in = 0, adj_sw = 0, btn_sec = 0, btn_min = 0, btn_hr = 0;
  logic adj_led;
  logic [5:0] sec_o, min_o;
  logic [4:0] hr_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hms_keeper #(.DEB_WAIT(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .adj_sw(adj_sw),
    .btn_sec(btn_sec), .btn_min(btn_min), .btn_hr(btn_hr),
    .adj_led(adj_led), .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o)
  );

  // behavioural reference: delayed input history, sample slots, clock arithmetic
  int m_sec = 0, m_min = 0, m_hr = 0;
  int q_in[$];                 // input words waiting to come out of the synchronizer
  int slot = 0;
  int smp[3][$];               // recent samples per button
  int prev_tick = 0;
  int held[3] = '{0, 0, 0};

  function automatic int pressed(int b);
    if (smp[b].size() < 3) return 0;
    return smp[b][0] & smp[b][1] & smp[b][2];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; slot = 0; prev_tick = 0;
      q_in = '{0, 0};
      for (int b = 0; b < 3; b++) begin smp[b] = {}; held[b] = 0; end
    end else begin
      int word, t, a;
      int pr[3];
      word = q_in[0];
      t = word & 1;
      a = (word >> 1) & 1;
      for (int b = 0; b < 3; b++) pr[b] = pressed(b);
      if (!a) begin
        if (t && !prev_tick) begin
          m_sec++;
          if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
              m_min = 0; m_hr++;
              if (m_hr == 24) m_hr = 0;
            end
          end
        end
      end else begin
        if (pr[0] && !held[0]) m_sec = (m_sec + 1) % 60;
        if (pr[1] && !held[1]) m_min = (m_min + 1) % 60;
        if (pr[2] && !held[2]) m_hr  = (m_hr + 1) % 24;
      end
      prev_tick = t;
      for (int b = 0; b < 3; b++) held[b] = a ? pr[b] : 0;
      if (slot == 0) begin
        for (int b = 0; b < 3; b++) begin
          smp[b].push_front((word >> (2 + b)) & 1);
          if (smp[b].size() > 3) void'(smp[b].pop_back());
        end
      end
      slot = (slot + 1) % W;
      void'(q_in.pop_front());
      q_in.push_back({27'd0, btn_hr, btn_min, btn_sec, adj_sw, tick_in});
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2/R6 model sec", int'(sec_o), m_sec);
      chk("R2/R6 model min", int'(min_o), m_min);
      chk("R2/R6 model hr",  int'(hr_o),  m_hr);
      chk("R8 led", int'(adj_led), int'(adj_sw));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick1();
    tick_in = 1; cyc(3); tick_in = 0; cyc(3);
  endtask

  task automatic press(logic [2:0] m, int n);
    for (int i = 0; i < n; i++) begin
      {btn_hr, btn_min, btn_sec} = m; cyc(4*W);
      {btn_hr, btn_min, btn_sec} = 3'b000; cyc(4*W);
    end
  endtask

  task automatic fields(string tag, int h, int m, int s);
    chk(tag, int'(hr_o), h);
    chk(tag, int'(min_o), m);
    chk(tag, int'(sec_o), s);
  endtask

  initial begin
    cyc(3);
    fields("R1 reset", 0, 0, 0);
    rst_n = 1;
    cyc(2);
    fields("R1 after release", 0, 0, 0);
    chk("R8 led low", int'(adj_led), 0);

    for (int i = 0; i < 5; i++) tick1();
    fields("R2 five ticks", 0, 0, 5);

    tick_in = 1; cyc(2);
    chk("R9 not yet", int'(sec_o), 5);
    cyc(1);
    chk("R9 third edge", int'(sec_o), 6);
    cyc(40);
    chk("R3 long high once", int'(sec_o), 6);
    tick_in = 0; cyc(4);

    adj_sw = 1; cyc(1);
    chk("R8 led high", int'(adj_led), 1);
    cyc(4);
    for (int i = 0; i < 3; i++) tick1();
    fields("R4 ticks ignored", 0, 0, 6);

    btn_sec = 1; cyc(2*W); btn_sec = 0; cyc(5*W);
    chk("R5 short pulse ignored", int'(sec_o), 6);

    press(3'b001, 54);
    fields("R6 sec wrap no carry", 0, 0, 0);
    press(3'b111, 23);
    fields("R6 all three stepped", 23, 23, 23);
    press(3'b100, 1);
    fields("R6 hr wrap alone", 0, 23, 23);
    press(3'b100, 23);
    press(3'b011, 35);
    press(3'b010, 1);
    fields("R6 preset", 23, 59, 58);

    tick_in = 1; cyc(3);
    adj_sw = 0; cyc(10);
    chk("R7 exit with tick high", int'(sec_o), 58);
    tick_in = 0; cyc(4);
    tick1();
    fields("R2 one tick", 23, 59, 59);
    tick1();
    fields("R2 full wrap", 0, 0, 0);
    for (int i = 0; i < 62; i++) tick1();
    fields("R2 minute carry", 0, 1, 2);

    adj_sw = 1; cyc(5);
    btn_hr = 1; cyc(5*W);
    chk("R7 first hold", int'(hr_o), 1);
    adj_sw = 0; cyc(10);
    adj_sw = 1; cyc(10);
    chk("R7 held across reentry", int'(hr_o), 2);
    btn_hr = 0; cyc(5*W);
    fields("R6 final", 2, 1, 2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule